// File: doc/BRIEF.md
# Token Ring Channel Access Node

This block is one station on a unidirectional token ring. The ring hands out exclusive, network-wide use of a set of nested recovery virtual channels. There is one token per channel. A token carries only its channel id, and free tokens move from station to station, one hop per clock. Strict ordering applies between these channels, so the recovery path itself cannot deadlock. When the local router must divert a blocked packet into a recovery channel, it raises the request bit for that channel. The station then takes the matching token off the ring and pulses a grant. The token is now considered to travel with the diverted packet. It is not returned when the local send finishes. It goes back into circulation only when the receiving side reports that the packet has arrived, through the release input of the station at the destination.

Each station registers its ring output, so a token that is not taken reappears downstream one cycle later. A station can receive a released token in the same cycle as a passing token. In that case it parks the released token in a small per-channel waiting set and sends it one cycle behind the passing one. Waiting tokens always leave before newly arriving ones. One station per ring is marked as the injector. Its waiting set starts full at reset, so it sends every token once, in ascending id order. Packet transport and deadlock detection belong to other blocks.

Top module: `tokring_node`

## Requirements
- R1: While reset is held, no station drives a token and all grant bits are 0. After reset is released, the injector station outputs channel ids 0, 1, ..., NUM_CH-1 on consecutive cycles, starting in the first cycle. Stations that are not the injector output nothing until a token reaches them.
- R2: A token that arrives while the station has no request bit set for its id, and has no waiting token, appears on the ring output in the next cycle with the same id.
- R3: A token whose id has its request bit set is captured. In the next cycle, grant bit number id (bit i stands for channel i) is 1 for exactly one cycle, and that token is not on the ring output.
- R4: Request bits for other ids have no effect on an arriving token. No grant bit is raised, and the token is forwarded.
- R5: A release of channel id c, made while no token arrives and none is waiting, puts c on the ring output in the next cycle.
- R6: A release made in the same cycle as a passing token, with none waiting, outputs the passing token in the next cycle and the released id one cycle after that. Waiting tokens leave, lowest id first, ahead of any newly arriving token.
- R7: No token is ever duplicated or dropped. Each id appears at most once across all ring links, all held tokens and all waiting tokens. On a ring with as many stations as channels, once it is idle, every link carries a distinct token.
- R8: A captured token does not appear on any ring link until it has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ringInValid | input | 1 | A token arrives from the upstream station |
| ringInCh | input | CH_W | Channel id of the arriving token |
| ringOutValid | output | 1 | A token leaves toward the downstream station |
| ringOutCh | output | CH_W | Channel id of the leaving token |
| reqVec | input | NUM_CH | Pending capture request, one bit per channel (level) |
| grantVec | output | NUM_CH | One-cycle capture grant, bit i for channel i |
| relValid | input | 1 | Destination reports reception; reinject a token |
| relCh | input | CH_W | Channel id of the token being reinjected |

## Verification
Every result of the block is registered once. A grant, a forwarded token or a captured gap appears one cycle after the arrival that causes it. A release appears one cycle later when the output is free, and two cycles later when it has to queue behind a passing token. The bench drives inputs and samples outputs on the falling edge. It keeps the link values and request bits from the previous sample, predicts each station's grant from them, and compares that prediction one sample later. The directed release and injection checks are made at exactly the sample the requirement names. Conservation and exclusivity are checked at every sample against the bench's own record of which tokens it holds.

// File: rtl/tokring_pkg.sv
`timescale 1ns/1ps
package tokring_pkg;

  // Strobes from control to datapath, one decision per cycle
  typedef struct packed {
    logic capture;   // arriving token taken for the local request
    logic fwdIn;     // arriving token goes straight to the output
    logic parkIn;    // arriving token waits one round inside the node
    logic emitHeld;  // lowest waiting token goes to the output
    logic emitRel;   // released token goes straight to the output
    logic parkRel;   // released token waits inside the node
  } tokStrobe_t;

  function automatic int chWidth(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tokring_ctrl.sv
`timescale 1ns/1ps
module tokring_ctrl
  import tokring_pkg::*;
(
  input  logic       ringInValid,
  input  logic       reqHit,
  input  logic       heldAny,
  input  logic       relValid,
  output tokStrobe_t strobe
);

  logic passIn;

  always_comb begin
    passIn          = ringInValid && !reqHit;
    strobe.capture  = ringInValid && reqHit;
    // waiting tokens beat arrivals; arrivals beat releases
    strobe.emitHeld = heldAny;
    strobe.fwdIn    = passIn && !heldAny;
    strobe.parkIn   = passIn && heldAny;
    strobe.emitRel  = relValid && !heldAny && !passIn;
    strobe.parkRel  = relValid && (heldAny || passIn);
  end

endmodule

// File: rtl/tokring_dp.sv
`timescale 1ns/1ps
module tokring_dp
  import tokring_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter bit IS_INJECTOR = 1'b0,
  localparam int CH_W       = chWidth(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   ringInCh,
  input  logic [NUM_CH-1:0] reqVec,
  input  logic [CH_W-1:0]   relCh,
  input  tokStrobe_t        strobe,
  output logic              reqHit,
  output logic              heldAny,
  output logic [NUM_CH-1:0] holdVec,
  output logic              ringOutValid,
  output logic [CH_W-1:0]   ringOutCh,
  output logic [NUM_CH-1:0] grantVec
);

  localparam logic [NUM_CH-1:0] ONE_V   = NUM_CH'(1);
  localparam logic [NUM_CH-1:0] INIT_HV = IS_INJECTOR ? {NUM_CH{1'b1}} : '0;

  logic [NUM_CH-1:0] inHot;
  logic [NUM_CH-1:0] relHot;
  logic [NUM_CH-1:0] heldHot;
  logic [CH_W-1:0]   heldCh;
  logic [NUM_CH-1:0] holdNext;
  logic              outValidNext;
  logic [CH_W-1:0]   outChNext;

  // per-channel id decode of the arriving and the released token
  for (genvar g = 0; g < NUM_CH; g++) begin : g_decode
    assign inHot[g]  = (ringInCh == CH_W'(g));
    assign relHot[g] = (relCh == CH_W'(g));
  end

  assign reqHit  = |(reqVec & inHot);
  assign heldAny = |holdVec;
  // isolate lowest waiting channel
  assign heldHot = holdVec & (~holdVec + ONE_V);

  always_comb begin
    heldCh = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (heldHot[i]) heldCh = heldCh | CH_W'(i);
    end
  end

  always_comb begin
    holdNext = holdVec;
    if (strobe.emitHeld) holdNext = holdNext & ~heldHot;
    if (strobe.parkIn)   holdNext = holdNext | inHot;
    if (strobe.parkRel)  holdNext = holdNext | relHot;
  end

  always_comb begin
    outValidNext = strobe.emitHeld || strobe.fwdIn || strobe.emitRel;
    if (strobe.emitHeld)   outChNext = heldCh;
    else if (strobe.fwdIn) outChNext = ringInCh;
    else                   outChNext = relCh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdVec      <= INIT_HV;
      ringOutValid <= 1'b0;
      ringOutCh    <= '0;
      grantVec     <= '0;
    end else begin
      holdVec      <= holdNext;
      ringOutValid <= outValidNext;
      if (outValidNext) ringOutCh <= outChNext;
      grantVec     <= strobe.capture ? inHot : '0;
    end
  end

endmodule

// File: rtl/tokring_node.sv
`timescale 1ns/1ps
module tokring_node
  import tokring_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter bit IS_INJECTOR = 1'b0,
  localparam int CH_W       = chWidth(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ringInValid,
  input  logic [CH_W-1:0]   ringInCh,
  output logic              ringOutValid,
  output logic [CH_W-1:0]   ringOutCh,
  input  logic [NUM_CH-1:0] reqVec,
  output logic [NUM_CH-1:0] grantVec,
  input  logic              relValid,
  input  logic [CH_W-1:0]   relCh
);

  tokStrobe_t        strobe;
  logic              reqHit;
  logic              heldAny;
  logic [NUM_CH-1:0] holdVec;

  tokring_ctrl u_ctrl (
    .ringInValid (ringInValid),
    .reqHit      (reqHit),
    .heldAny     (heldAny),
    .relValid    (relValid),
    .strobe      (strobe)
  );

  tokring_dp #(
    .NUM_CH      (NUM_CH),
    .IS_INJECTOR (IS_INJECTOR)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .ringInCh     (ringInCh),
    .reqVec       (reqVec),
    .relCh        (relCh),
    .strobe       (strobe),
    .reqHit       (reqHit),
    .heldAny      (heldAny),
    .holdVec      (holdVec),
    .ringOutValid (ringOutValid),
    .ringOutCh    (ringOutCh),
    .grantVec     (grantVec)
  );

endmodule

// File: rtl/tokring_node_chk.sv
`timescale 1ns/1ps
module tokring_node_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ringInValid,
  input logic [CH_W-1:0]   ringInCh,
  input logic              ringOutValid,
  input logic [CH_W-1:0]   ringOutCh,
  input logic [NUM_CH-1:0] reqVec,
  input logic [NUM_CH-1:0] grantVec,
  input logic              relValid,
  input logic [CH_W-1:0]   relCh,
  input logic [NUM_CH-1:0] holdVec
);

  logic [NUM_CH-1:0] inBit;
  logic              inReq;
  assign inBit = NUM_CH'(1) << ringInCh;
  assign inReq = |(reqVec & inBit);

  AST_FWD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ringInValid && !inReq && holdVec == '0 |=> ringOutValid && ringOutCh == $past(ringInCh)); // R2

  AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    grantVec != '0 |-> $past(ringInValid) && grantVec == (NUM_CH'(1) << $past(ringInCh))
                       && ($past(reqVec) & grantVec) != '0); // R3

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec)); // R3

  AST_CAPTURE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ringInValid && inReq && holdVec == '0 && !relValid |=> !ringOutValid); // R3

  AST_NO_FOREIGN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(ringInValid && inReq) |=> grantVec == '0); // R4

  AST_REL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    relValid && !ringInValid && holdVec == '0 |=> ringOutValid && ringOutCh == $past(relCh)); // R5

  AST_REL_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
    relValid && ringInValid && !inReq && holdVec == '0
      |=> ##1 (ringOutValid && ringOutCh == $past(relCh, 2))); // R6

endmodule

bind tokring_node tokring_node_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ringInValid  (ringInValid),
  .ringInCh     (ringInCh),
  .ringOutValid (ringOutValid),
  .ringOutCh    (ringOutCh),
  .reqVec       (reqVec),
  .grantVec     (grantVec),
  .relValid     (relValid),
  .relCh        (relCh),
  .holdVec      (holdVec)
);

// File: tb/tokring_node_bench.sv
`timescale 1ns/1ps
module tokring_node_bench;

  localparam int NCH   = 4;
  localparam int NNODE = 4;
  localparam int CH_W  = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic            linkV  [NNODE];
  logic [CH_W-1:0] linkCh [NNODE];
  logic [NCH-1:0]  reqV   [NNODE];
  logic [NCH-1:0]  grant  [NNODE];
  logic            relV   [NNODE];
  logic [CH_W-1:0] relC   [NNODE];

  for (genvar i = 0; i < NNODE; i++) begin : g_node
    tokring_node #(.NUM_CH(NCH), .IS_INJECTOR(i == 0)) u_tokring_node (
      .clk          (clk),
      .rst_n        (rst_n),
      .ringInValid  (linkV[(i + NNODE - 1) % NNODE]),
      .ringInCh     (linkCh[(i + NNODE - 1) % NNODE]),
      .ringOutValid (linkV[i]),
      .ringOutCh    (linkCh[i]),
      .reqVec       (reqV[i]),
      .grantVec     (grant[i]),
      .relValid     (relV[i]),
      .relCh        (relC[i])
    );
  end

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;
  bit  randomOn = 0;
  bit  reqOn    = 0;
  bit  heldTok  [NCH];
  int  holdTimer[NCH];
  logic            pLinkV [NNODE];
  logic [CH_W-1:0] pLinkCh[NNODE];
  logic [NCH-1:0]  pReq   [NNODE];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] predGrant(input int n);
    int up = (n + NNODE - 1) % NNODE;
    if (pLinkV[up] && pReq[n][pLinkCh[up]]) return NCH'(1) << pLinkCh[up];
    return '0;
  endfunction

  task automatic monitor();
    int seen[NCH];
    for (int c = 0; c < NCH; c++) seen[c] = 0;
    for (int n = 0; n < NNODE; n++) begin
      logic [NCH-1:0] exp = predGrant(n);
      check(grant[n] == exp, (exp != '0) ? "R3 grant" : "R4 no grant", int'(grant[n]), int'(exp));
      for (int c = 0; c < NCH; c++) begin
        if (grant[n][c]) begin
          heldTok[c]   = 1'b1;
          holdTimer[c] = 2 + int'($urandom % 20);
          reqV[n][c]   = 1'b0;
        end
      end
    end
    for (int n = 0; n < NNODE; n++) begin
      if (linkV[n]) begin
        seen[linkCh[n]]++;
        check(!heldTok[linkCh[n]], "R8 held token on ring", int'(linkCh[n]), -1);
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (heldTok[c]) seen[c]++;
      check(seen[c] <= 1, "R7 duplicate token", seen[c], 1);
    end
  endtask

  task automatic stimulus();
    if (!randomOn) return;
    for (int c = 0; c < NCH; c++) begin
      if (heldTok[c] && holdTimer[c] == 0) begin
        int d = int'($urandom % NNODE);
        relV[d]    = 1'b1;
        relC[d]    = CH_W'(c);
        heldTok[c] = 1'b0;
        break;
      end
    end
    for (int c = 0; c < NCH; c++)
      if (heldTok[c] && holdTimer[c] > 0) holdTimer[c]--;
    if (reqOn) begin
      for (int n = 0; n < NNODE; n++)
        if (reqV[n] == '0 && ($urandom % 6) == 0) reqV[n] = NCH'(1) << ($urandom % NCH);
    end
  endtask

  task automatic runCycle();
    for (int n = 0; n < NNODE; n++) begin
      pLinkV[n] = linkV[n]; pLinkCh[n] = linkCh[n]; pReq[n] = reqV[n];
    end
    @(negedge clk);
    for (int n = 0; n < NNODE; n++) relV[n] = 1'b0;
    monitor();
    stimulus();
  endtask

  task automatic checkFullRing(input string tag);
    int seen[NCH];
    for (int c = 0; c < NCH; c++) seen[c] = 0;
    for (int n = 0; n < NNODE; n++) begin
      check(linkV[n] == 1'b1, tag, int'(linkV[n]), 1);
      if (linkV[n]) seen[linkCh[n]]++;
    end
    for (int c = 0; c < NCH; c++) check(seen[c] == 1, tag, seen[c], 1);
  endtask

  initial begin
    int p;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    for (int n = 0; n < NNODE; n++) begin
      reqV[n] = '0; relV[n] = 1'b0; relC[n] = '0;
    end
    for (int c = 0; c < NCH; c++) begin heldTok[c] = 0; holdTimer[c] = 0; end
    repeat (3) @(negedge clk);
    // R1: silent during reset
    for (int n = 0; n < NNODE; n++) begin
      check(linkV[n] == 1'b0, "R1 reset output", int'(linkV[n]), 0);
      check(grant[n] == '0, "R1 reset grant", int'(grant[n]), 0);
    end
    rst_n = 1'b1;
    // R1/R2: ascending injection, forwarded one hop per cycle
    for (int i = 0; i < NCH; i++) begin
      runCycle();
      check(linkV[0] && linkCh[0] == CH_W'(i), "R1 injection order", int'(linkCh[0]), i);
      if (i == 0) check(linkV[1] == 1'b0, "R1 non-injector silent", int'(linkV[1]), 0);
      else check(linkV[1] && linkCh[1] == CH_W'(i - 1), "R2 forward", int'(linkCh[1]), i - 1);
    end
    repeat (16) runCycle();
    checkFullRing("R7 idle ring");
    // R2 directed: idle ring forwards every hop
    for (int k = 0; k < 4; k++) begin
      runCycle();
      check(linkV[2] && linkCh[2] == pLinkCh[1], "R2 forward", int'(linkCh[2]), int'(pLinkCh[1]));
    end
    // R3: capture channel 2 at node 2
    reqV[2] = NCH'(1) << 2;
    for (int k = 0; k < 10 && !heldTok[2]; k++) runCycle();
    check(heldTok[2], "R3 capture happened", int'(heldTok[2]), 1);
    check(grant[2] == 4'b0100, "R3 grant bit", int'(grant[2]), 4);
    check(linkV[2] == 1'b0, "R3 token removed", int'(linkV[2]), 0);
    runCycle();
    check(grant[2] == '0, "R3 grant one cycle", int'(grant[2]), 0);
    // R5: release at node 3 when its input is empty
    while (linkV[2]) runCycle();
    relV[3] = 1'b1; relC[3] = 2'd2; heldTok[2] = 1'b0;
    runCycle();
    check(linkV[3] && linkCh[3] == 2'd2, "R5 release next cycle", int'(linkCh[3]), 2);
    repeat (12) runCycle();
    // R6: capture channel 1 at node 1, release at node 3 behind a passing token
    reqV[1] = NCH'(1) << 1;
    for (int k = 0; k < 10 && !heldTok[1]; k++) runCycle();
    check(heldTok[1], "R3 capture happened", int'(heldTok[1]), 1);
    runCycle();
    while (!linkV[2]) runCycle();
    p = int'(linkCh[2]);
    relV[3] = 1'b1; relC[3] = 2'd1; heldTok[1] = 1'b0;
    runCycle();
    check(linkV[3] && int'(linkCh[3]) == p, "R6 passing token first", int'(linkCh[3]), p);
    runCycle();
    check(linkV[3] && linkCh[3] == 2'd1, "R6 release one cycle behind", int'(linkCh[3]), 1);
    repeat (12) runCycle();
    checkFullRing("R7 after releases");
    // random phase
    randomOn = 1; reqOn = 1;
    repeat (3000) runCycle();
    reqOn = 0;
    for (int n = 0; n < NNODE; n++) reqV[n] = '0;
    for (int k = 0; k < 200; k++) begin
      bit any = 0;
      for (int c = 0; c < NCH; c++) any |= heldTok[c];
      if (!any) break;
      runCycle();
    end
    repeat (30) runCycle();
    checkFullRing("R7 after random traffic");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule